// File: doc/BRIEF.md
# Shared-Counter Set-Associative Cache Tag Controller

This block holds the tags and valid bits of a unified four-way set-associative cache and decides, for each request, whether the addressed line is present. Instruction and data requests use the same request port and the same arrays, so they compete for lines. The cache has 128 sets and 16-byte lines. A hit is answered in the cycle the request is presented, together with the way that holds the line. A miss is answered by a line-fill request to a memory port. When the memory reports that the fill is complete, the controller writes the new tag and answers the requester.

Victim choice is deliberately simple. If the indexed set has a free way, the lowest-numbered free way receives the new line. If every way is valid, the way named by a single 2-bit counter is replaced. This counter is shared by the whole cache. Only such evictions advance the counter. Hits and allocations into free ways leave it untouched. As a result, stale blocks can stay resident for a long time, and a block that was just loaded can be evicted by an access to an unrelated set.

Top module: `shared_ctr_cache_tags`

## Requirements
- R1: A byte address splits into bits [3:0] line offset, bits [10:4] set index, and bits [31:11] tag. Memory block i (address bits [31:4]) therefore maps to set i mod 128, and two addresses in the same block get the same result.
- R2: A request presented while `reqReady` is high that matches a valid tag in its set raises `respValid` and `respHit` in the same cycle, with `respWay` giving the matching way.
- R3: A request that misses raises `fillReq` from the next cycle on. `fillAddr` equals the requested byte address, and both stay stable until `fillDone` is seen.
- R4: In the cycle `fillDone` is high during a fill, `respValid` is high, `respHit` is low and `respWay` names the allocated way. Afterwards the line hits, and `fillReq` is low in the next cycle.
- R5: When the indexed set has an invalid way, the miss allocates the lowest-numbered invalid way and the shared counter does not change.
- R6: When all four ways of the set are valid, the miss replaces way number `counter`, and the counter then advances by one modulo 4.
- R7: Hits never change the shared counter.
- R8: After reset all lines are invalid, the counter is 0, `reqReady` is 1, and `fillReq` and `respValid` are 0.
- R9: `invalidateAll` takes effect at the next clock edge. It clears every valid bit, sets the counter to 0, abandons any fill in progress without installing it, and suppresses `respValid` in its own cycle.
- R10: While a fill is outstanding, `reqReady` is low and requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqAddr | input | 32 | Byte address of the request |
| reqReady | output | 1 | Controller can take a request |
| respValid | output | 1 | Hit or miss result valid this cycle |
| respHit | output | 1 | Result is a hit |
| respWay | output | 2 | Way holding, or now holding, the line |
| fillReq | output | 1 | Line fill requested |
| fillAddr | output | 32 | Requested byte address for the fill |
| fillDone | input | 1 | Memory finished the fill |
| invalidateAll | input | 1 | Clear all lines and the counter |

## Verification
The hardest state to reach is a full set combined with a known counter value, because the counter is never visible at the ports. The stimulus therefore first sweeps blocks 0 to 511 in order to fill every way of every set. It then issues a scripted sequence of conflicting misses across several sets, interleaved with hits, so that the position of the hidden counter is inferred from the returned way of each eviction. This sequence includes re-fetching blocks that were evicted earlier and evicting a block loaded shortly before. A second phase invalidates everything in the middle of a fill and then refills one set to show that the counter restarts at 0.

// File: rtl/sctc_pkg.sv
package sctc_pkg;
  // Strobes from the control to the tag datapath
  typedef struct packed {
    logic capture;  // latch request and choose victim
    logic commit;   // write tag/valid, advance counter on eviction
    logic flush;    // clear all valid bits and the counter
  } sctc_strobe_t;
endpackage

// File: rtl/sctc_datapath.sv
module sctc_datapath
  import sctc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS = 128,
  parameter int WAYS = 4,
  parameter int LINE_BYTES = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  sctc_strobe_t              strobe,
  input  logic [ADDR_W-1:0]         reqAddr,
  output logic                      hit,
  output logic [$clog2(WAYS)-1:0]   hitWay,
  output logic [WAYS-1:0]           hitVec,
  output logic [$clog2(WAYS)-1:0]   allocWay,
  output logic [ADDR_W-1:0]         fillAddr,
  output logic [$clog2(WAYS)-1:0]   ctrVal
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [TAG_W-1:0] tagMem [SETS][WAYS];
  logic [WAYS-1:0]  validMem [SETS];
  logic [ADDR_W-1:0] heldAddr;
  logic [WAY_W-1:0] victimWay;
  logic             victimEvicts;
  logic [WAY_W-1:0] shareCtr;

  logic [IDX_W-1:0] reqIdx;
  logic [TAG_W-1:0] reqTag;
  logic [IDX_W-1:0] heldIdx;
  logic [TAG_W-1:0] heldTag;
  logic [WAY_W-1:0] freeWay;
  logic             setFull;

  assign reqIdx  = reqAddr[OFF_W +: IDX_W];
  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign heldIdx = heldAddr[OFF_W +: IDX_W];
  assign heldTag = heldAddr[ADDR_W-1 -: TAG_W];

  // Parallel compare across all ways
  for (genvar w = 0; w < WAYS; w++) begin : gCmp
    assign hitVec[w] = validMem[reqIdx][w] && (tagMem[reqIdx][w] == reqTag);
  end

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (hitVec[w]) hitWay = WAY_W'(w);
  end
  assign hit = |hitVec;

  // Lowest-numbered invalid way
  always_comb begin
    freeWay = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!validMem[reqIdx][w]) freeWay = WAY_W'(w);
  end
  assign setFull = &validMem[reqIdx];

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      heldAddr     <= reqAddr;
      victimWay    <= setFull ? shareCtr : freeWay;
      victimEvicts <= setFull;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.commit && !strobe.flush)
      tagMem[heldIdx][victimWay] <= heldTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      for (int s = 0; s < SETS; s++) validMem[s] <= '0;
      shareCtr <= '0;
    end else if (strobe.commit) begin
      validMem[heldIdx][victimWay] <= 1'b1;
      if (victimEvicts) shareCtr <= shareCtr + WAY_W'(1);
    end
  end

  assign allocWay = victimWay;
  assign fillAddr = heldAddr;
  assign ctrVal   = shareCtr;
endmodule

// File: rtl/sctc_control.sv
module sctc_control
  import sctc_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    invalidateAll,
  input  logic                    fillDone,
  input  logic                    hit,
  input  logic [$clog2(WAYS)-1:0] hitWay,
  input  logic [$clog2(WAYS)-1:0] allocWay,
  output sctc_strobe_t            strobe,
  output logic                    reqReady,
  output logic                    fillReq,
  output logic                    respValid,
  output logic                    respHit,
  output logic [$clog2(WAYS)-1:0] respWay
);
  typedef enum logic {IDLE, FILL} ctl_state_t;
  ctl_state_t state, stateNext;

  logic idleNow, fillNow;
  assign idleNow = (state == IDLE);
  assign fillNow = (state == FILL);

  always_comb begin
    strobe.flush   = invalidateAll;
    strobe.capture = idleNow && reqValid && !hit && !invalidateAll;
    strobe.commit  = fillNow && fillDone && !invalidateAll;
  end

  always_comb begin
    stateNext = state;
    if (invalidateAll)       stateNext = IDLE;
    else if (strobe.capture) stateNext = FILL;
    else if (strobe.commit)  stateNext = IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= IDLE;
    else       state <= stateNext;
  end

  assign reqReady  = idleNow;
  assign fillReq   = fillNow;
  assign respHit   = idleNow && reqValid && hit && !invalidateAll;
  assign respValid = respHit || strobe.commit;
  assign respWay   = fillNow ? allocWay : hitWay;
endmodule

// File: rtl/shared_ctr_cache_tags.sv
module shared_ctr_cache_tags
  import sctc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS = 128,
  parameter int WAYS = 4,
  parameter int LINE_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [ADDR_W-1:0]       reqAddr,
  output logic                    reqReady,
  output logic                    respValid,
  output logic                    respHit,
  output logic [$clog2(WAYS)-1:0] respWay,
  output logic                    fillReq,
  output logic [ADDR_W-1:0]       fillAddr,
  input  logic                    fillDone,
  input  logic                    invalidateAll
);
  localparam int WAY_W = $clog2(WAYS);

  sctc_strobe_t     strobe;
  logic             hit;
  logic [WAY_W-1:0] hitWay;
  logic [WAYS-1:0]  hitVec;
  logic [WAY_W-1:0] allocWay;
  logic [WAY_W-1:0] ctrVal;

  sctc_datapath #(
    .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .hit(hit), .hitWay(hitWay), .hitVec(hitVec), .allocWay(allocWay),
    .fillAddr(fillAddr), .ctrVal(ctrVal)
  );

  sctc_control #(.WAYS(WAYS)) uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .invalidateAll(invalidateAll),
    .fillDone(fillDone), .hit(hit), .hitWay(hitWay), .allocWay(allocWay),
    .strobe(strobe), .reqReady(reqReady), .fillReq(fillReq),
    .respValid(respValid), .respHit(respHit), .respWay(respWay)
  );
endmodule

// File: rtl/sctc_checker.sv
module sctc_checker #(
  parameter int ADDR_W = 32,
  parameter int WAYS = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    reqReady,
  input logic                    respValid,
  input logic                    respHit,
  input logic                    fillReq,
  input logic [ADDR_W-1:0]       fillAddr,
  input logic                    fillDone,
  input logic                    invalidateAll,
  input logic [WAYS-1:0]         hitVec,
  input logic [$clog2(WAYS)-1:0] ctrVal
);
  a_r1_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  a_r2_hit_is_valid: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respValid);

  a_r3_fill_held: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && !fillDone && !invalidateAll) |=> (fillReq && fillAddr == $past(fillAddr)));

  a_r4_miss_resp_on_done: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (fillReq && fillDone));

  // R5, R7: counter moves only on a completed fill
  a_r7_ctr_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!invalidateAll && !(fillReq && fillDone)) |=> ctrVal == $past(ctrVal));

  a_r9_flush: assert property (@(posedge clk) disable iff (!rstN)
    invalidateAll |=> (ctrVal == '0 && !fillReq));

  a_r10_busy: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> !reqReady);
endmodule

bind shared_ctr_cache_tags sctc_checker #(.ADDR_W(ADDR_W), .WAYS(WAYS)) uChk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .respValid(respValid),
  .respHit(respHit), .fillReq(fillReq), .fillAddr(fillAddr), .fillDone(fillDone),
  .invalidateAll(invalidateAll), .hitVec(hitVec), .ctrVal(ctrVal)
);

// File: tb/sim_shared_ctr_cache_tags.sv
module sim_shared_ctr_cache_tags;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqReady, respValid, respHit, fillReq;
  logic [1:0]  respWay;
  logic [31:0] fillAddr;
  logic        fillDone = 1'b0;
  logic        invalidateAll = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  shared_ctr_cache_tags u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .respValid(respValid), .respHit(respHit),
    .respWay(respWay), .fillReq(fillReq), .fillAddr(fillAddr),
    .fillDone(fillDone), .invalidateAll(invalidateAll)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One request; on a miss, wait holdCycles then complete the fill.
  task automatic access(input logic [31:0] a, input int holdCycles,
                        output logic gotHit, output int gotWay,
                        output logic [31:0] gotFill);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; #1;
    if (respValid && respHit) begin
      gotHit = 1'b1; gotWay = int'(respWay); gotFill = '0;
      @(negedge clk); reqValid = 1'b0;
    end else begin
      gotHit = 1'b0;
      @(negedge clk); reqValid = 1'b0; #1;
      gotFill = fillReq ? fillAddr : 32'hFFFF_FFFF;
      repeat (holdCycles) @(negedge clk);
      fillDone = 1'b1; #1;
      gotWay = (respValid && !respHit) ? int'(respWay) : 9;
      @(negedge clk); fillDone = 1'b0;
    end
  endtask

  // {address, expected hit, expected way}; counter starts at 0 with all sets full
  localparam logic [34:0] VECS [18] = '{
    {32'h0000_2000, 1'b0, 2'd0}, {32'h0000_2013, 1'b0, 2'd1},
    {32'h0000_2020, 1'b0, 2'd2}, {32'h0000_2030, 1'b0, 2'd3},
    {32'h0000_2040, 1'b0, 2'd0}, {32'h0000_0000, 1'b0, 2'd1},
    {32'h0000_2009, 1'b1, 2'd0}, {32'h0000_0010, 1'b1, 2'd0},
    {32'h0000_0810, 1'b0, 2'd2}, {32'h0000_201F, 1'b1, 2'd1},
    {32'h0000_0800, 1'b0, 2'd3}, {32'h0000_0004, 1'b1, 2'd1},
    {32'h0000_2800, 1'b0, 2'd0}, {32'h0000_2000, 1'b0, 2'd1},
    {32'h0000_0000, 1'b0, 2'd2}, {32'h0000_0007, 1'b1, 2'd2},
    {32'h8000_0000, 1'b0, 2'd3}, {32'h8000_000C, 1'b1, 2'd3}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic h; int w; logic [31:0] f;
    repeat (3) @(negedge clk);
    rstN = 1'b1; #1;
    check("R8 reqReady after reset", reqReady, 1);
    check("R8 fillReq after reset", fillReq, 0);
    check("R8 respValid after reset", respValid, 0);

    // Blocks 0..511 fill every set, lowest free way first (R5, R1)
    for (int i = 0; i < 512; i++) begin
      access(32'(i * 16), 0, h, w, f);
      check("R5 sweep miss", h, 0);
      check("R5 sweep way", w, i / 128);
      check("R3 sweep fillAddr", f, i * 16);
    end

    // Shared counter sequence (R6, R7, R2, R1, R4)
    for (int v = 0; v < 18; v++) begin
      access(VECS[v][34:3], 1, h, w, f);
      check(VECS[v][2] ? "R2 table hit" : "R6 table miss", h, VECS[v][2]);
      check(VECS[v][2] ? "R2 table way" : "R6 table victim way", w, VECS[v][1:0]);
      if (!VECS[v][2]) check("R3 table fillAddr", f, VECS[v][34:3]);
    end

    // Fill hold and busy ignore; counter is now 0 -> way 0 (R3, R10, R4)
    @(negedge clk); reqValid = 1'b1; reqAddr = 32'h0000_1005; #1;
    check("R3 miss no response", respValid, 0);
    @(negedge clk); reqAddr = 32'h0000_2000; #1;
    check("R10 not ready during fill", reqReady, 0);
    check("R10 busy request ignored", respValid, 0);
    check("R3 fillReq raised", fillReq, 1);
    check("R3 fillAddr", fillAddr, 32'h0000_1005);
    repeat (2) @(negedge clk); #1;
    check("R3 fillReq held", fillReq, 1);
    check("R3 fillAddr held", fillAddr, 32'h0000_1005);
    reqValid = 1'b0; fillDone = 1'b1; #1;
    check("R4 done respValid", respValid, 1);
    check("R4 done respHit", respHit, 0);
    check("R4 done way", respWay, 0);
    @(negedge clk); fillDone = 1'b0; #1;
    check("R4 fillReq dropped", fillReq, 0);
    check("R10 ready again", reqReady, 1);
    access(32'h0000_100F, 0, h, w, f);
    check("R1 same block hits", h, 1);
    check("R1 same block way", w, 0);

    // Invalidate in the middle of a fill (R9)
    @(negedge clk); reqValid = 1'b1; reqAddr = 32'h0000_3000;
    @(negedge clk); reqValid = 1'b0; invalidateAll = 1'b1; fillDone = 1'b1; #1;
    check("R9 respValid suppressed", respValid, 0);
    @(negedge clk); invalidateAll = 1'b0; fillDone = 1'b0; #1;
    check("R9 fill abandoned", fillReq, 0);
    check("R9 ready", reqReady, 1);
    access(32'h0000_0010, 0, h, w, f);
    check("R9 former hit now misses", h, 0);
    check("R9 lowest way after flush", w, 0);
    access(32'h0000_3000, 0, h, w, f);
    check("R9 aborted line not installed", h, 0);
    // Fill set 5 then evict twice: counter restarted at 0
    for (int k = 0; k < 4; k++) begin
      access(32'((5 + 128 * k) * 16), 0, h, w, f);
      check("R5 set5 fill way", w, k);
    end
    access(32'(517 * 16), 0, h, w, f);
    check("R9 counter zero after flush", w, 0);
    access(32'(645 * 16), 0, h, w, f);
    check("R6 counter advanced", w, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule